// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block resolves one operand of a small 16-bit register-oriented processor. The decode stage gives it a strobe and five inputs: an addressing-mode code, a role flag (source or destination), the register number and that register's current contents, the program counter, and the extension word that follows the opcode. One cycle later the block reports the operand's kind: register, immediate, memory or rejected. For memory operands it gives the effective address. For the post-increment mode it also gives a register write-back request.

Register 0 is the program counter, register 1 the stack pointer, register 2 the status register and register 3 a constant source. Registers 4 to 15 are general purpose. The PC-relative and absolute forms need no register operand. The first adds the extension word to the program counter input. The second uses the extension word with a base of zero. A destination accepts only the first four modes. Any other destination request is flagged and causes no side effect.

Top module: `eag_top`

## Requirements
- R1: All outputs are registered. `res_vld_o` is high exactly in the cycle after a cycle with `strb_i` high. When no strobe was given, every other output keeps its previous value.
- R2: Mode code 0 (register) gives kind 0 (register), address 0 and no write-back.
- R3: Mode code 1 (indexed) gives kind 2 (memory) and address = extension word + register contents, modulo 2^16.
- R4: Mode code 2 (symbolic) gives kind 2 and address = program counter + extension word, modulo 2^16.
- R5: Mode code 3 (absolute) gives kind 2 and address = extension word.
- R6: Mode code 4 (indirect), as a source, gives kind 2, address = register contents and no write-back.
- R7: Mode code 5 (auto-increment), as a source with a word access (`byte_i`=0), gives kind 2 and address = register contents. It also raises `wb_en_o` for the same register, with value = contents + 2.
- R8: In mode code 5 with a byte access (`byte_i`=1), the write-back value is contents + 1. For register 0 or 1 it is contents + 2.
- R9: Mode code 6 (immediate), as a source, gives kind 1 (immediate), `imm_o` = extension word, address 0 and no write-back.
- R10: A destination (`dst_i`=1) with mode 4, 5 or 6, or any operand with the unused code 7, raises `bad_mode_o` and gives kind 3, address 0 and no write-back. `bad_mode_o` is low for every accepted request.
- R11: After synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_i | input | 1 | Request strobe |
| dst_i | input | 1 | 0 = source operand, 1 = destination operand |
| mode_i | input | 3 | Addressing-mode code (0..6, 7 unused) |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| reg_i | input | 4 | Register number |
| rval_i | input | 16 | Contents of the selected register |
| pc_i | input | 16 | Program counter value |
| ext_i | input | 16 | Extension word |
| res_vld_o | output | 1 | Result valid, one cycle after the strobe |
| kind_o | output | 2 | 0 register, 1 immediate, 2 memory, 3 rejected |
| ea_o | output | 16 | Effective address |
| imm_o | output | 16 | Immediate operand value |
| wb_en_o | output | 1 | Register write-back request |
| wb_reg_o | output | 4 | Register to write back |
| wb_val_o | output | 16 | Write-back value |
| bad_mode_o | output | 1 | Mode not allowed for this role |

## Verification
Each mode is driven as a source and, where legal, as a destination. The destination runs show that the role flag alone separates accepted requests from rejected ones. The post-increment mode is driven with word and byte sizes on a general register, the program counter and the stack pointer. These runs show apart the step of 1 and the alignment-preserving step of 2. The address sums use values near 0xFFFF to show 16-bit wrap. Idle gaps between strobes show that the outputs hold.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    AM_REG = 3'd0,
    AM_IDX = 3'd1,
    AM_SYM = 3'd2,
    AM_ABS = 3'd3,
    AM_IND = 3'd4,
    AM_INC = 3'd5,
    AM_IMM = 3'd6,
    AM_RSV = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    OK_REG  = 2'd0,
    OK_IMM  = 2'd1,
    OK_MEM  = 2'd2,
    OK_NONE = 2'd3
  } okind_e;
endpackage

// File: rtl/eag_legal.sv
module eag_legal
  import eag_pkg::*;
#(
  parameter int DST_MODES = 4
) (
  input  amode_e mode,
  input  logic   dst,
  output logic   legal
);
  localparam int SRC_MODES = 7;

  always_comb begin
    if (dst) legal = (int'(mode) < DST_MODES);
    else     legal = (int'(mode) < SRC_MODES);
  end
endmodule

// File: rtl/eag_addr.sv
module eag_addr
  import eag_pkg::*;
#(
  parameter int DW = 16
) (
  input  amode_e        mode,
  input  logic [DW-1:0] rval,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] ext,
  output logic [DW-1:0] ea,
  output okind_e        kind
);
  localparam logic [DW-1:0] ABS_BASE = '0;

  always_comb begin
    ea   = '0;
    kind = OK_NONE;
    unique case (mode)
      AM_REG: kind = OK_REG;
      AM_IDX: begin kind = OK_MEM; ea = ext + rval;     end
      AM_SYM: begin kind = OK_MEM; ea = pc + ext;       end
      AM_ABS: begin kind = OK_MEM; ea = ABS_BASE + ext; end
      AM_IND: begin kind = OK_MEM; ea = rval;           end
      AM_INC: begin kind = OK_MEM; ea = rval;           end
      AM_IMM: kind = OK_IMM;
      AM_RSV: kind = OK_NONE;
    endcase
  end
endmodule

// File: rtl/eag_step.sv
module eag_step #(
  parameter int DW         = 16,
  parameter int RW         = 4,
  parameter int PC_IDX     = 0,
  parameter int SP_IDX     = 1,
  parameter int WORD_STEP  = 2,
  parameter int BYTE_STEP  = 1,
  parameter bit KEEP_ALIGN = 1'b1
) (
  input  logic [RW-1:0] reg_idx,
  input  logic          is_byte,
  input  logic [DW-1:0] rval,
  output logic [DW-1:0] nxt
);
  localparam logic [DW-1:0] WSTEP = DW'(WORD_STEP);
  localparam logic [DW-1:0] BSTEP = DW'(BYTE_STEP);
  localparam logic [RW-1:0] PC_R  = RW'(PC_IDX);
  localparam logic [RW-1:0] SP_R  = RW'(SP_IDX);

  logic force_word;

  generate
    if (KEEP_ALIGN) begin : g_align
      assign force_word = (reg_idx == PC_R) || (reg_idx == SP_R);
    end else begin : g_noalign
      assign force_word = 1'b0;
    end
  endgenerate

  always_comb begin
    if (is_byte && !force_word) nxt = rval + BSTEP;
    else                        nxt = rval + WSTEP;
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int DW        = 16,
  parameter int NREG      = 16,
  parameter int PC_IDX    = 0,
  parameter int SP_IDX    = 1,
  parameter int WORD_STEP = 2,
  parameter int BYTE_STEP = 1,
  parameter int DST_MODES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     strb_i,
  input  logic                     dst_i,
  input  logic [2:0]               mode_i,
  input  logic                     byte_i,
  input  logic [$clog2(NREG)-1:0]  reg_i,
  input  logic [DW-1:0]            rval_i,
  input  logic [DW-1:0]            pc_i,
  input  logic [DW-1:0]            ext_i,
  output logic                     res_vld_o,
  output logic [1:0]               kind_o,
  output logic [DW-1:0]            ea_o,
  output logic [DW-1:0]            imm_o,
  output logic                     wb_en_o,
  output logic [$clog2(NREG)-1:0]  wb_reg_o,
  output logic [DW-1:0]            wb_val_o,
  output logic                     bad_mode_o
);
  localparam int RW = $clog2(NREG);

  amode_e        mode;
  logic          legal;
  logic [DW-1:0] ea_c, nxt_c;
  okind_e        kind_c;

  assign mode = amode_e'(mode_i);

  eag_legal #(.DST_MODES(DST_MODES)) legal_i (
    .mode(mode), .dst(dst_i), .legal(legal)
  );

  eag_addr #(.DW(DW)) addr_i (
    .mode(mode), .rval(rval_i), .pc(pc_i), .ext(ext_i),
    .ea(ea_c), .kind(kind_c)
  );

  eag_step #(
    .DW(DW), .RW(RW), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX),
    .WORD_STEP(WORD_STEP), .BYTE_STEP(BYTE_STEP), .KEEP_ALIGN(1'b1)
  ) step_i (
    .reg_idx(reg_i), .is_byte(byte_i), .rval(rval_i), .nxt(nxt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld_o  <= 1'b0;
      kind_o     <= '0;
      ea_o       <= '0;
      imm_o      <= '0;
      wb_en_o    <= 1'b0;
      wb_reg_o   <= '0;
      wb_val_o   <= '0;
      bad_mode_o <= 1'b0;
    end else begin
      res_vld_o <= strb_i;
      if (strb_i) begin
        bad_mode_o <= !legal;
        if (legal) begin
          kind_o   <= kind_c;
          ea_o     <= ea_c;
          imm_o    <= (kind_c == OK_IMM) ? ext_i : '0;
          wb_en_o  <= (mode == AM_INC);
          wb_reg_o <= reg_i;
          wb_val_o <= (mode == AM_INC) ? nxt_c : '0;
        end else begin
          kind_o   <= OK_NONE;
          ea_o     <= '0;
          imm_o    <= '0;
          wb_en_o  <= 1'b0;
          wb_reg_o <= '0;
          wb_val_o <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int DW        = 16,
  parameter int RW        = 4,
  parameter int PC_IDX    = 0,
  parameter int SP_IDX    = 1,
  parameter int WORD_STEP = 2,
  parameter int BYTE_STEP = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          strb_i,
  input logic          res_vld_o,
  input logic [1:0]    kind_o,
  input logic [DW-1:0] ea_o,
  input logic          wb_en_o,
  input logic [RW-1:0] wb_reg_o,
  input logic [DW-1:0] wb_val_o,
  input logic          bad_mode_o
);
  logic [DW-1:0] step;
  assign step = wb_val_o - ea_o;

  assert_strobe_to_valid_R1: assert property (@(posedge clk) disable iff (rst)
    strb_i |=> res_vld_o);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !strb_i |=> (!res_vld_o && $stable(ea_o) && $stable(kind_o) && $stable(wb_en_o)));
  assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    bad_mode_o |-> (!wb_en_o && kind_o == 2'd3 && ea_o == '0));
  assert_wb_is_memory_R7: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> (kind_o == 2'd2 && !bad_mode_o));
  assert_step_size_R8: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> (step == DW'(WORD_STEP) || step == DW'(BYTE_STEP)));
  assert_pc_sp_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_en_o && (wb_reg_o == RW'(PC_IDX) || wb_reg_o == RW'(SP_IDX)))
      |-> step == DW'(WORD_STEP));
  assert_imm_no_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (kind_o == 2'd1) |-> (!wb_en_o && ea_o == '0));
endmodule

bind eag_top eag_chk #(
  .DW(DW), .RW(RW), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX),
  .WORD_STEP(WORD_STEP), .BYTE_STEP(BYTE_STEP)
) chk_i (
  .clk(clk), .rst(rst), .strb_i(strb_i), .res_vld_o(res_vld_o),
  .kind_o(kind_o), .ea_o(ea_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
  .wb_val_o(wb_val_o), .bad_mode_o(bad_mode_o)
);

// File: tb/eag_top_tb_top.sv
module eag_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strb_i = 1'b0, dst_i = 1'b0, byte_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [3:0]  reg_i = '0;
  logic [15:0] rval_i = '0, pc_i = '0, ext_i = '0;
  logic        res_vld_o, wb_en_o, bad_mode_o;
  logic [1:0]  kind_o;
  logic [15:0] ea_o, imm_o, wb_val_o;
  logic [3:0]  wb_reg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [1:0]  kind;
    logic [15:0] ea, imm, wbv;
    logic        wbe, bad;
    logic [3:0]  wbr;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eag_top dut_i (
    .clk(clk), .rst(rst), .strb_i(strb_i), .dst_i(dst_i), .mode_i(mode_i),
    .byte_i(byte_i), .reg_i(reg_i), .rval_i(rval_i), .pc_i(pc_i), .ext_i(ext_i),
    .res_vld_o(res_vld_o), .kind_o(kind_o), .ea_o(ea_o), .imm_o(imm_o),
    .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_val_o(wb_val_o),
    .bad_mode_o(bad_mode_o)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic drive(input string tag, input bit d, input logic [2:0] m,
                       input bit b, input logic [3:0] r, input logic [15:0] rv,
                       input logic [15:0] pc, input logic [15:0] x);
    exp_t e;
    e.tag = tag; e.kind = 2'd3; e.ea = '0; e.imm = '0; e.wbv = '0;
    e.wbe = 1'b0; e.bad = 1'b0; e.wbr = '0;
    if (m == 3'd7 || (d && m >= 3'd4)) e.bad = 1'b1;
    else begin
      e.wbr = r;
      case (m)
        3'd0: e.kind = 2'd0;
        3'd1: begin e.kind = 2'd2; e.ea = x + rv; end
        3'd2: begin e.kind = 2'd2; e.ea = pc + x; end
        3'd3: begin e.kind = 2'd2; e.ea = x; end
        3'd4: begin e.kind = 2'd2; e.ea = rv; end
        3'd5: begin
          e.kind = 2'd2; e.ea = rv; e.wbe = 1'b1;
          e.wbv = rv + ((b && r > 4'd1) ? 16'd1 : 16'd2);
        end
        default: begin e.kind = 2'd1; e.imm = x; end
      endcase
    end
    @(negedge clk);
    sb.push_back(e);
    strb_i = 1'b1; dst_i = d; mode_i = m; byte_i = b; reg_i = r;
    rval_i = rv; pc_i = pc; ext_i = x;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strb_i = 1'b0;
      rval_i = 16'hDEAD; ext_i = 16'hBEEF; mode_i = 3'd1;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && res_vld_o) begin
      if (sb.size() == 0) check(1'b0, "R1", "result with no pending request");
      else begin
        exp_t e;
        e = sb.pop_front();
        check(kind_o == e.kind && ea_o == e.ea && imm_o == e.imm &&
              wb_en_o == e.wbe && wb_val_o == e.wbv && bad_mode_o == e.bad &&
              (!e.wbe || wb_reg_o == e.wbr), e.tag,
              $sformatf("got k=%0d ea=%h imm=%h wb=%b/%0d/%h bad=%b exp k=%0d ea=%h imm=%h wb=%b/%0d/%h bad=%b",
                        kind_o, ea_o, imm_o, wb_en_o, wb_reg_o, wb_val_o, bad_mode_o,
                        e.kind, e.ea, e.imm, e.wbe, e.wbr, e.wbv, e.bad));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", "run did not complete (got hang, exp finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check(res_vld_o == 0 && kind_o == 0 && ea_o == 0 && imm_o == 0 && wb_en_o == 0 &&
          wb_reg_o == 0 && wb_val_o == 0 && bad_mode_o == 0, "R11",
          $sformatf("got vld=%b k=%0d ea=%h exp all zero", res_vld_o, kind_o, ea_o));
    drive("R2 src", 0, 3'd0, 0, 4'd7, 16'h1234, 16'h0100, 16'h5555);
    drive("R2 dst", 1, 3'd0, 1, 4'd9, 16'h1234, 16'h0100, 16'h5555);
    drive("R3 src", 0, 3'd1, 0, 4'd5, 16'h0200, 16'h0100, 16'h0002);
    drive("R3 wrap", 1, 3'd1, 1, 4'd6, 16'hFFF0, 16'h0100, 16'h0020);
    drive("R3 sp", 0, 3'd1, 0, 4'd1, 16'h03FE, 16'h0100, 16'hFFFE);
    drive("R4 src", 0, 3'd2, 0, 4'd0, 16'h9999, 16'hC010, 16'h0040);
    drive("R4 dst wrap", 1, 3'd2, 0, 4'd0, 16'h0, 16'hFFFE, 16'h0004);
    drive("R5 src", 0, 3'd3, 1, 4'd2, 16'h7777, 16'h0100, 16'h0172);
    drive("R5 dst", 1, 3'd3, 0, 4'd2, 16'h7777, 16'h0100, 16'h0021);
    idle(3);
    // R1: outputs hold while idle
    check(res_vld_o == 0 && ea_o == 16'h0021 && kind_o == 2'd2, "R1",
          $sformatf("got vld=%b ea=%h exp vld=0 ea=0021", res_vld_o, ea_o));
    drive("R6 src", 0, 3'd4, 0, 4'd10, 16'h0A00, 16'h0100, 16'h1111);
    drive("R6 src byte", 0, 3'd4, 1, 4'd0, 16'hF002, 16'h0100, 16'h1111);
    drive("R7 word", 0, 3'd5, 0, 4'd10, 16'h0A00, 16'h0100, 16'h0);
    drive("R7 wrap", 0, 3'd5, 0, 4'd15, 16'hFFFE, 16'h0100, 16'h0);
    drive("R8 byte gp", 0, 3'd5, 1, 4'd4, 16'h0301, 16'h0100, 16'h0);
    drive("R8 byte pc", 0, 3'd5, 1, 4'd0, 16'hC000, 16'hC000, 16'h0);
    drive("R8 byte sp", 0, 3'd5, 1, 4'd1, 16'h0400, 16'h0100, 16'h0);
    drive("R8 word sp", 0, 3'd5, 0, 4'd1, 16'h0402, 16'h0100, 16'h0);
    drive("R8 byte r2", 0, 3'd5, 1, 4'd2, 16'h0010, 16'h0100, 16'h0);
    drive("R9 word", 0, 3'd6, 0, 4'd0, 16'h0, 16'h0100, 16'h002D);
    drive("R9 byte", 0, 3'd6, 1, 4'd0, 16'h0, 16'h0100, 16'hFF80);
    drive("R10 dst ind", 1, 3'd4, 0, 4'd8, 16'h0800, 16'h0100, 16'h0);
    drive("R10 dst inc", 1, 3'd5, 0, 4'd8, 16'h0800, 16'h0100, 16'h0);
    drive("R10 dst imm", 1, 3'd6, 0, 4'd0, 16'h0, 16'h0100, 16'h1234);
    drive("R10 src rsv", 0, 3'd7, 0, 4'd3, 16'h0, 16'h0100, 16'h1234);
    drive("R10 recover", 1, 3'd1, 0, 4'd4, 16'h0010, 16'h0100, 16'h0005);
    idle(4);
    check(sb.size() == 0, "R1", $sformatf("got %0d pending exp 0", sb.size()));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule